// File: doc/BRIEF.md
# Colour Lookup Table with Output Format Conversion

This block holds the colour table of an LCD controller: 256 colour entries of 16 bits, stored as 128 words of 32 bits so that a single bus write fills two neighbouring entries. Each entry carries three 5-bit colour channels and one intensity bit that plays no part in the colour. A bus port writes whole words, and a second bus port returns any word exactly as it was written.

A pixel path presents an 8-bit pixel index together with an output format code. One cycle later the block returns the selected entry with each channel widened to 8 bits and repacked into the requested format: 8-bit 3-3-2, 15-bit 5-5-5, 16-bit 5-6-5 or 24-bit 8-8-8. The format is chosen per request, so a display path can switch formats at run time without touching the table.

Top module: `palette_lut`

## Requirements
- R1: After reset every stored word reads as zero, `lk_valid` and `rd_valid` are low, and `lk_color` and `rd_data` are zero.
- R2: A word written with `wr_en` at `wr_addr` is returned unchanged on `rd_data`, all 32 bits including bits 15 and 31, one cycle after a request with `rd_en` at that address; `rd_valid` is high in exactly the cycle after each `rd_en`, and `rd_data` is zero while `rd_valid` is low.
- R3: Pixel index `lk_idx` selects word `lk_idx[7:1]`; `lk_idx[0]`=0 takes bits [15:0] of that word and `lk_idx[0]`=1 takes bits [31:16].
- R4: Within an entry, red is bits [4:0], green bits [9:5] and blue bits [14:10]; each channel is widened to 8 bits with three zero bits below it, and bit 15 has no effect on the colour.
- R5: Format code 0 gives {red[7:5], green[7:5], blue[7:6]} in `lk_color[7:0]`, with bits [23:8] zero.
- R6: Format code 1 gives {red[7:3], green[7:3], blue[7:3]} in `lk_color[14:0]`, with bits [23:15] zero.
- R7: Format code 2 gives {red[7:3], green[7:2], blue[7:3]} in `lk_color[15:0]`, with bits [23:16] zero.
- R8: Format code 3 gives red in `lk_color[23:16]`, green in [15:8] and blue in [7:0].
- R9: `lk_valid` is high in exactly the cycle after each `lk_en`; `lk_color` is zero whenever `lk_valid` is low.
- R10: A lookup or a readback issued in the same cycle as a write to the same word returns the word's value from before that write.
- R11: The format applied to a result is the `lk_fmt` value present with its request, not the value in the result cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write one table word |
| wr_addr | input | 7 | Word address of the write |
| wr_data | input | 32 | Word to store (two packed entries) |
| rd_en | input | 1 | Request a raw word readback |
| rd_addr | input | 7 | Word address to read back |
| rd_valid | output | 1 | Readback result present |
| rd_data | output | 32 | Raw word, zero when not valid |
| lk_en | input | 1 | Request a pixel lookup |
| lk_idx | input | 8 | Pixel index into the 256-entry table |
| lk_fmt | input | 2 | Output format code of this request |
| lk_valid | output | 1 | Lookup result present |
| lk_color | output | 24 | Converted colour, zero when not valid |

## Verification
The assertions assume the request and write inputs are at known levels from the first clock after reset, and that a readback checked against an earlier write follows that write by exactly one cycle. The bench drives every input on the falling edge from defined values, holds them at zero through reset, and mixes directed sequences with random traffic over a small range of word addresses so that writes, readbacks and lookups collide on the same word often. The format code is changed between consecutive requests so that a late sampling of it shows up in the results.

// File: rtl/pal_pkg.sv
package pal_pkg;

  typedef enum logic [1:0] {
    FMT_332 = 2'd0,
    FMT_555 = 2'd1,
    FMT_565 = 2'd2,
    FMT_888 = 2'd3
  } pix_fmt_e;

  localparam int CHAN_IN_W  = 5;
  localparam int CHAN_OUT_W = 8;
  localparam int COLOR_W    = 3 * CHAN_OUT_W;

  typedef struct packed {
    logic [CHAN_OUT_W-1:0] red;
    logic [CHAN_OUT_W-1:0] grn;
    logic [CHAN_OUT_W-1:0] blu;
  } rgb8_t;

  // Widen the three 5-bit channels of an entry (intensity bit excluded).
  function automatic rgb8_t widen_entry(input logic [3*CHAN_IN_W-1:0] e);
    rgb8_t c;
    c.red = {e[CHAN_IN_W-1:0],             3'b000};
    c.grn = {e[2*CHAN_IN_W-1:CHAN_IN_W],   3'b000};
    c.blu = {e[3*CHAN_IN_W-1:2*CHAN_IN_W], 3'b000};
    return c;
  endfunction

  // Repack an 8-8-8 colour into the selected display format.
  function automatic logic [COLOR_W-1:0] pack_color(input rgb8_t c, input pix_fmt_e f);
    logic [COLOR_W-1:0] o;
    case (f)
      FMT_332: o = {16'h0, c.red[7:5], c.grn[7:5], c.blu[7:6]};
      FMT_555: o = {9'h0,  c.red[7:3], c.grn[7:3], c.blu[7:3]};
      FMT_565: o = {8'h0,  c.red[7:3], c.grn[7:2], c.blu[7:3]};
      default: o = {c.red, c.grn, c.blu};
    endcase
    return o;
  endfunction

endpackage

// File: rtl/pal_store.sv
module pal_store #(
  parameter int WORDS  = 128,
  parameter int WORD_W = 32,
  localparam int AW    = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              lk_re,
  input  logic [AW-1:0]     lk_addr,
  output logic [WORD_W-1:0] lk_word,
  input  logic              bus_re,
  input  logic [AW-1:0]     bus_addr,
  output logic [WORD_W-1:0] bus_word
);

  logic [WORD_W-1:0] mem [WORDS];

  // One register per word; a write lands at the edge, so reads in the
  // same cycle see the previous contents.
  for (genvar w = 0; w < WORDS; w++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         mem[w] <= '0;
      else if (we && waddr == AW'(w))     mem[w] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lk_word  <= '0;
      bus_word <= '0;
    end else begin
      if (lk_re)  lk_word  <= mem[lk_addr];
      if (bus_re) bus_word <= mem[bus_addr];
    end
  end

endmodule

// File: rtl/pal_convert.sv
module pal_convert
  import pal_pkg::*;
#(
  parameter int WORD_W = 32,
  localparam int ENTRY_W = WORD_W / 2
) (
  input  logic [WORD_W-1:0]  word,
  input  logic               hi_half,
  input  pix_fmt_e           fmt,
  output logic [COLOR_W-1:0] color
);

  logic [ENTRY_W-1:0] entry;
  logic               unused_intensity;

  assign entry            = hi_half ? word[WORD_W-1:ENTRY_W] : word[ENTRY_W-1:0];
  assign unused_intensity = entry[ENTRY_W-1];
  assign color            = pack_color(widen_entry(entry[3*CHAN_IN_W-1:0]), fmt);

endmodule

// File: rtl/palette_lut.sv
module palette_lut
  import pal_pkg::*;
#(
  parameter int WORDS  = 128,
  parameter int WORD_W = 32,
  localparam int AW    = $clog2(WORDS),
  localparam int IW    = AW + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_addr,
  input  logic [WORD_W-1:0]  wr_data,
  input  logic               rd_en,
  input  logic [AW-1:0]      rd_addr,
  output logic               rd_valid,
  output logic [WORD_W-1:0]  rd_data,
  input  logic               lk_en,
  input  logic [IW-1:0]      lk_idx,
  input  logic [1:0]         lk_fmt,
  output logic               lk_valid,
  output logic [COLOR_W-1:0] lk_color
);

  logic [WORD_W-1:0]  lk_word, bus_word;
  logic               half_q;
  logic [1:0]         fmt_q;
  logic               lk_valid_q, rd_valid_q;
  logic [COLOR_W-1:0] conv_color;

  pal_store #(.WORDS(WORDS), .WORD_W(WORD_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (wr_en),
    .waddr    (wr_addr),
    .wdata    (wr_data),
    .lk_re    (lk_en),
    .lk_addr  (lk_idx[IW-1:1]),
    .lk_word  (lk_word),
    .bus_re   (rd_en),
    .bus_addr (rd_addr),
    .bus_word (bus_word)
  );

  // Half select and format are captured with the request.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q     <= 1'b0;
      fmt_q      <= 2'd0;
      lk_valid_q <= 1'b0;
      rd_valid_q <= 1'b0;
    end else begin
      lk_valid_q <= lk_en;
      rd_valid_q <= rd_en;
      if (lk_en) begin
        half_q <= lk_idx[0];
        fmt_q  <= lk_fmt;
      end
    end
  end

  pal_convert #(.WORD_W(WORD_W)) u_conv (
    .word    (lk_word),
    .hi_half (half_q),
    .fmt     (pix_fmt_e'(fmt_q)),
    .color   (conv_color)
  );

  assign lk_valid = lk_valid_q;
  assign lk_color = lk_valid_q ? conv_color : '0;
  assign rd_valid = rd_valid_q;
  assign rd_data  = rd_valid_q ? bus_word : '0;

endmodule

// File: rtl/pal_checker.sv
module pal_checker #(
  parameter int AW      = 7,
  parameter int WORD_W  = 32,
  parameter int COLOR_W = 24
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic [AW-1:0]      wr_addr,
  input logic [WORD_W-1:0]  wr_data,
  input logic               rd_en,
  input logic [AW-1:0]      rd_addr,
  input logic               rd_valid,
  input logic [WORD_W-1:0]  rd_data,
  input logic               lk_en,
  input logic               lk_valid,
  input logic [COLOR_W-1:0] lk_color,
  input logic [1:0]         fmt_q
);

  p_lk_valid_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lk_en |=> lk_valid);
  p_lk_valid_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_en |=> !lk_valid);
  p_lk_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> lk_color == '0);

  p_fmt332_upper_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && fmt_q == 2'd0) |-> lk_color[COLOR_W-1:8] == '0);
  p_fmt555_upper_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && fmt_q == 2'd1) |-> lk_color[COLOR_W-1:15] == '0);
  p_fmt565_upper_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && fmt_q == 2'd2) |-> lk_color[COLOR_W-1:16] == '0);
  p_fmt888_lowbits_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && fmt_q == 2'd3) |->
      (lk_color[2:0] == 3'b0 && lk_color[10:8] == 3'b0 && lk_color[18:16] == 3'b0));

  p_rd_valid_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  p_rd_valid_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (!rd_valid && rd_data == '0));
  p_readback_exact_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en) && rd_en && rd_addr == $past(wr_addr)) |=> rd_data == $past(wr_data, 2));

endmodule

bind palette_lut pal_checker #(.AW(AW), .WORD_W(WORD_W), .COLOR_W(pal_pkg::COLOR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data),
  .rd_en    (rd_en),
  .rd_addr  (rd_addr),
  .rd_valid (rd_valid),
  .rd_data  (rd_data),
  .lk_en    (lk_en),
  .lk_valid (lk_valid),
  .lk_color (lk_color),
  .fmt_q    (fmt_q)
);

// File: tb/tb_palette_lut.sv
module tb_palette_lut;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [6:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [6:0]  rd_addr = '0;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic        lk_en = 1'b0;
  logic [7:0]  lk_idx = '0;
  logic [1:0]  lk_fmt = '0;
  logic        lk_valid;
  logic [23:0] lk_color;

  always #5 clk = ~clk;

  palette_lut dut (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .lk_en(lk_en), .lk_idx(lk_idx), .lk_fmt(lk_fmt),
    .lk_valid(lk_valid), .lk_color(lk_color)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  // Reference model state
  int unsigned model [128];
  bit          e_lk_valid = 0;
  int unsigned e_lk_color = 0;
  bit          e_rd_valid = 0;
  int unsigned e_rd_data  = 0;
  string       lk_tag = "R1";
  string       rd_tag = "R1";

  function automatic int unsigned ref_color(int unsigned word, int idx_low, int f);
    int unsigned e, r, g, b;
    e = idx_low ? (word / 65536) : (word % 65536);
    r = (e % 32) * 8;
    g = ((e / 32) % 32) * 8;
    b = ((e / 1024) % 32) * 8;
    case (f)
      0: return (r / 32) * 32 + (g / 32) * 4 + b / 64;
      1: return (r / 8) * 1024 + (g / 8) * 32 + b / 8;
      2: return (r / 8) * 2048 + (g / 4) * 32 + b / 8;
      default: return r * 65536 + g * 256 + b;
    endcase
  endfunction

  function automatic string fmt_tag(int f);
    case (f)
      0: return "R5";
      1: return "R6";
      2: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(bit ok, string tag, string what, int unsigned act, int unsigned exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("[TB] FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  // Compare the previous cycle's expectations, then present new inputs.
  task automatic step(bit we, int wa, int unsigned wd, bit re, int ra,
                      bit le, int li, int f, string ph);
    @(negedge clk);
    check(lk_valid == e_lk_valid, {lk_tag, " R9"}, "lk_valid", 32'(lk_valid), 32'(e_lk_valid));
    check(lk_color == 24'(e_lk_color), lk_tag, "lk_color", 32'(lk_color), e_lk_color);
    check(rd_valid == e_rd_valid, {rd_tag, " R2"}, "rd_valid", 32'(rd_valid), 32'(e_rd_valid));
    check(rd_data == e_rd_data, rd_tag, "rd_data", rd_data, e_rd_data);

    e_lk_valid = le;
    e_lk_color = le ? ref_color(model[li / 2], li % 2, f) : 0;
    lk_tag = (ph != "") ? ph : fmt_tag(f);
    if (le && we && wa == li / 2) lk_tag = {lk_tag, " R10"};
    e_rd_valid = re;
    e_rd_data  = re ? model[ra] : 0;
    rd_tag = (ph != "") ? ph : "R2";
    if (re && we && wa == ra) rd_tag = {rd_tag, " R10"};
    if (we) model[wa] = wd;

    wr_en = we; wr_addr = 7'(wa); wr_data = wd;
    rd_en = re; rd_addr = 7'(ra);
    lk_en = le; lk_idx = 8'(li); lk_fmt = 2'(f);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("[TB] FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 128; i++) model[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset contents and idle outputs; sweep every word on both ports.
    for (int i = 0; i < 128; i++)
      step(0, 0, 0, 1, i, 1, 2 * i + (i % 2), i % 4, "R1");

    // R2 R4: raw readback keeps intensity bits; colour ignores them.
    step(1, 3, 32'h8000_FFFF, 0, 0, 0, 0, 0, "");
    step(1, 4, 32'h7FFF_0000, 0, 0, 0, 0, 0, "");
    step(0, 0, 0, 1, 3, 0, 0, 0, "R2");
    step(0, 0, 0, 1, 4, 0, 0, 0, "R2");
    // R3 R4: both halves in every format, format changing per request (R11).
    for (int f = 0; f < 4; f++) begin
      step(0, 0, 0, 0, 0, 1, 6, f, "R3 R4 R11");
      step(0, 0, 0, 0, 0, 1, 7, 3 - f, "R3 R4 R11");
      step(0, 0, 0, 0, 0, 1, 8, f, "R3 R4 R11");
      step(0, 0, 0, 0, 0, 1, 9, (f + 1) % 4, "R3 R4 R11");
    end
    // Single-channel patterns through each format.
    step(1, 20, 32'h0000_001F, 0, 0, 0, 0, 0, "");
    step(1, 21, 32'h03E0_7C00, 0, 0, 0, 0, 0, "");
    for (int f = 0; f < 4; f++) begin
      step(0, 0, 0, 0, 0, 1, 40, f, "");
      step(0, 0, 0, 0, 0, 1, 42, f, "");
      step(0, 0, 0, 0, 0, 1, 43, f, "");
    end

    // R10: same-cycle write and read of one word returns the old value.
    step(1, 10, 32'h1234_5678, 0, 0, 0, 0, 0, "");
    step(1, 10, 32'hCAFE_F00D, 1, 10, 1, 21, 3, "R10");
    step(0, 0, 0, 1, 10, 1, 21, 3, "R10");
    step(0, 0, 0, 0, 0, 0, 0, 0, "");

    // Random traffic over a small word range to force collisions.
    for (int n = 0; n < 4000; n++) begin
      int wa = int'($urandom_range(0, 15));
      step(bit'($urandom_range(0, 1)), wa, $urandom(),
           bit'($urandom_range(0, 1)), int'($urandom_range(0, 15)),
           bit'($urandom_range(0, 3) != 0), int'($urandom_range(0, 31)),
           int'($urandom_range(0, 3)), "");
    end
    step(0, 0, 0, 0, 0, 0, 0, 0, "");
    step(0, 0, 0, 0, 0, 0, 0, 0, "");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule